// File: doc/BRIEF.md
# Microwire Serial EEPROM Word Reader

This block runs the read cycle of a small serial EEPROM on a three-wire Microwire port: select, serial clock, serial data towards the device, plus one data line coming back. A single start pulse fetches one 16-bit word at a given address. With the boot flag set, the same pulse walks through every word of the part, adds them up, and reports whether the total equals a fixed signature.

Each transaction works as follows. The select line goes high and the read command is clocked out. Address bits follow, most significant first. After each address bit the returned line is sampled. A low level there is the device's leading dummy zero: it means the part has taken its full address, so the sequencer moves straight to the data phase. In this way a part with a narrower address than the parameter allows is still read correctly. The clock's high and low phases come from a prescaler of the system clock.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, eeCs, eeSk, eeDi, busy, dataValid and sumOk are all 0.
- R2: eeCs rises before the first rising eeSk of a word, stays high through every eeSk pulse of that word, and falls after the last one. Between words in boot mode it goes low again.
- R3: Each word starts with the read command bits 1, 1, 0 in that order, presented on eeDi at the rising eeSk edges.
- R4: The word address follows the command, most significant bit first, one bit per eeSk pulse, and at most ADDR_W bits.
- R5: If eeDo is low at the end of an address bit's high phase, no further address bits are sent. A part with a k-bit address therefore sees exactly 3 + k + 16 eeSk pulses.
- R6: If eeDo never goes low during the address, all ADDR_W bits are sent and the 16 data pulses still follow. With eeDo held high the word reads 0xFFFF after 3 + ADDR_W + 16 pulses.
- R7: Sixteen data bits are taken from eeDo while eeSk is high, most significant first. In single-word mode they appear on rdData when dataValid is high.
- R8: Every eeSk high phase lasts exactly HALF_DIV clocks. Every eeSk low phase with eeCs high lasts exactly HALF_DIV clocks before the next rising eeSk.
- R9: In boot mode, words 0 to 2^ADDR_W - 1 are read in ascending order, one select period each. rdData then returns their sum modulo 2^16.
- R10: sumOk changes only while dataValid is high. It is 1 after a boot pass whose sum equals SIGNATURE (default 0xBABA) and 0 after a failed pass or after any single-word read.
- R11: busy is high from the cycle after an accepted start until the cycle in which dataValid pulses, for exactly one cycle. A start while busy is ignored.
- R12: eeDi is 0 during all data-phase pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| bootMode | input | 1 | 1: read and sum the whole image; 0: one word |
| wordAddr | input | ADDR_W | Word address for single-word mode |
| busy | output | 1 | Transaction in progress |
| dataValid | output | 1 | One-cycle result strobe |
| rdData | output | 16 | Word read, or image sum in boot mode |
| sumOk | output | 1 | Image sum matched the signature |
| eeCs | output | 1 | Device select |
| eeSk | output | 1 | Serial clock |
| eeDi | output | 1 | Serial data to device |
| eeDo | input | 1 | Serial data from device |

## Verification
A bit counter or state that slips shows up on the wire within the same word. The bench sees a wrong number of eeSk pulses, an address received off by a bit, or a shifted data word on rdData at the next dataValid. Prescaler faults appear as wrong eeSk phase widths from the first pulse. Errors in the word counter or the accumulator show up only at the end of a boot pass, as a wrong address order, a wrong word count, a wrong sum on rdData, or a wrong sumOk. So both a good image and a corrupted image are read in full.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

  localparam int WORD_W = 16;
  localparam int OPC_W  = 3;
  localparam logic [OPC_W-1:0] OPC_READ = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_TAIL,
    ST_GAP
  } mwState_t;

  typedef struct packed {
    logic startTxn;
    logic loadCmd;
    logic shiftOut;
    logic shiftIn;
    logic addSum;
    logic nextWord;
    logic finish;
    logic driveDi;
  } mwStrobes_t;

endpackage

// File: rtl/mw_rd_path.sv
module mw_rd_path
  import mw_rd_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobes_t        st,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              bootReq,
  input  logic              eeDo,
  output logic              eeDi,
  output logic              bootActive,
  output logic              lastWord,
  output logic [WORD_W-1:0] rdData,
  output logic              dataValid,
  output logic              sumOk
);

  localparam int OUT_W = OPC_W + ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [ADDR_W-1:0] addrQ;
  logic              bootQ;
  logic [OUT_W-1:0]  outSr;
  logic [WORD_W-1:0] inSr;
  logic [WORD_W-1:0] sumQ;
  logic [WORD_W-1:0] rdQ;
  logic              validQ;
  logic              okQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      bootQ  <= 1'b0;
      outSr  <= '0;
      inSr   <= '0;
      sumQ   <= '0;
      rdQ    <= '0;
      validQ <= 1'b0;
      okQ    <= 1'b0;
    end else begin
      validQ <= st.finish;
      if (st.startTxn) begin
        addrQ <= bootReq ? '0 : startAddr;
        bootQ <= bootReq;
      end else if (st.nextWord) begin
        addrQ <= addrQ + 1'b1;
      end
      if (st.loadCmd) begin
        outSr <= {OPC_READ, addrQ};
      end else if (st.shiftOut) begin
        outSr <= {outSr[OUT_W-2:0], 1'b0};
      end
      if (st.shiftIn) begin
        inSr <= {inSr[WORD_W-2:0], eeDo};
      end
      if (st.startTxn) begin
        sumQ <= '0;
      end else if (st.addSum) begin
        sumQ <= sumQ + inSr;
      end
      if (st.finish) begin
        rdQ <= bootQ ? sumQ : inSr;
        okQ <= bootQ && (sumQ == SIGNATURE);
      end
    end
  end

  assign eeDi       = st.driveDi & outSr[OUT_W-1];
  assign bootActive = bootQ;
  assign lastWord   = (addrQ == LAST_ADDR);
  assign rdData     = rdQ;
  assign dataValid  = validQ;
  assign sumOk      = okQ;

  // R11: result strobe lasts a single cycle
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R10: the checksum flag only moves together with the result strobe
  assert_ok_with_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sumOk) |-> dataValid);

  // R12: data line quiet while the device is shifting data out
  assert_di_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftIn |-> !eeDi);

endmodule

// File: rtl/mw_rd_ctrl.sv
module mw_rd_ctrl
  import mw_rd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int HALF_DIV = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       eeDo,
  input  logic       bootActive,
  input  logic       lastWord,
  output mwStrobes_t st,
  output logic       eeCs,
  output logic       eeSk,
  output logic       busy
);

  localparam int BIT_MAX = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int CNT_W   = $clog2(BIT_MAX + 1);

  mwState_t   state;
  logic [CNT_W-1:0] bitCnt;
  logic       diEn;
  logic       timed;
  logic       tick;
  logic       moreWords;

  assign timed = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA) ||
                 (state == ST_TAIL) || (state == ST_GAP);
  assign moreWords = bootActive && !lastWord;

  generate
    if (HALF_DIV <= 1) begin : g_noDiv
      assign tick = timed;
    end else begin : g_div
      localparam int DIV_W = $clog2(HALF_DIV + 1);
      logic [DIV_W-1:0] divQ;
      assign tick = timed && (divQ == DIV_W'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN || !timed || tick) divQ <= '0;
        else                         divQ <= divQ + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      eeCs   <= 1'b0;
      eeSk   <= 1'b0;
      bitCnt <= '0;
      busy   <= 1'b0;
      diEn   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          busy  <= 1'b1;
        end
        ST_LOAD: begin
          eeCs   <= 1'b1;
          diEn   <= 1'b1;
          bitCnt <= '0;
          state  <= ST_CMD;
        end
        ST_CMD, ST_ADDR, ST_DATA: if (tick) begin
          if (!eeSk) begin
            eeSk <= 1'b1;
          end else begin
            eeSk   <= 1'b0;
            bitCnt <= bitCnt + 1'b1;
            if (state == ST_CMD) begin
              if (bitCnt == CNT_W'(OPC_W - 1)) begin
                state  <= ST_ADDR;
                bitCnt <= '0;
              end
            end else if (state == ST_ADDR) begin
              if (!eeDo || bitCnt == CNT_W'(ADDR_W - 1)) begin
                state  <= ST_DATA;
                bitCnt <= '0;
                diEn   <= 1'b0;
              end
            end else begin
              if (bitCnt == CNT_W'(WORD_W - 1)) begin
                state  <= ST_TAIL;
                bitCnt <= '0;
              end
            end
          end
        end
        ST_TAIL: if (tick) begin
          eeCs  <= 1'b0;
          state <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (moreWords) begin
            state <= ST_LOAD;
          end else begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    st         = '0;
    st.driveDi = diEn;
    case (state)
      ST_IDLE: st.startTxn = start;
      ST_LOAD: st.loadCmd  = 1'b1;
      ST_CMD,
      ST_ADDR: st.shiftOut = tick && eeSk;
      ST_DATA: st.shiftIn  = tick && eeSk;
      ST_TAIL: st.addSum   = tick && bootActive;
      ST_GAP: begin
        st.nextWord = tick && moreWords;
        st.finish   = tick && !moreWords;
      end
      default: st = '0;
    endcase
  end

  // R2: no clock edge towards the device without select
  assert_sk_in_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> eeCs);

  // R5: address phase never runs past the configured width
  assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |-> (bitCnt < CNT_W'(ADDR_W)));

  // R8: serial clock only toggles on a prescaler tick
  assert_sk_on_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eeSk) |-> $past(tick));

  // R11: busy only rises in answer to a start request
  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_rd_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          HALF_DIV  = 125,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              bootMode,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic              busy,
  output logic              dataValid,
  output logic [15:0]       rdData,
  output logic              sumOk,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo
);

  mwStrobes_t strobes;
  logic       bootActive;
  logic       lastWord;

  mw_rd_ctrl #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .eeDo(eeDo),
    .bootActive(bootActive), .lastWord(lastWord), .st(strobes),
    .eeCs(eeCs), .eeSk(eeSk), .busy(busy)
  );

  mw_rd_path #(.ADDR_W(ADDR_W), .SIGNATURE(SIGNATURE)) uPath (
    .clk(clk), .rstN(rstN), .st(strobes), .startAddr(wordAddr),
    .bootReq(bootMode), .eeDo(eeDo), .eeDi(eeDi), .bootActive(bootActive),
    .lastWord(lastWord), .rdData(rdData), .dataValid(dataValid), .sumOk(sumOk)
  );

  // R11: busy ends exactly when the result is presented
  assert_busy_ends_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> dataValid);

endmodule

// File: tb/mw_eeprom_reader_test.sv
module mw_eeprom_reader_test;

  localparam int AW   = 6;
  localparam int HALF = 2;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic bootMode = 1'b0;
  logic [AW-1:0] wordAddr = '0;
  logic busy, dataValid, sumOk, eeCs, eeSk, eeDi;
  logic [15:0] rdData;
  logic devDo = 1'b1;
  logic stuckHigh = 1'b0;
  logic eeDo;

  assign eeDo = stuckHigh ? 1'b1 : devDo;

  always #4 clk = ~clk;

  mw_eeprom_reader #(.ADDR_W(AW), .HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .start(start), .bootMode(bootMode),
    .wordAddr(wordAddr), .busy(busy), .dataValid(dataValid), .rdData(rdData),
    .sumOk(sumOk), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [NW];
  int devW = AW;
  int rxCnt = 0;
  int dIdx = 0;
  logic [15:0] rxAddr = '0;
  logic [2:0] rxOpc = '0;
  int pulses = 0, csRises = 0, expAddr = 0;
  bit csErr = 0, diErr = 0, opcErr = 0, orderErr = 0;
  logic [15:0] lastAddr = '0;

  initial begin
    logic pCs, pSk;
    pCs = 1'b0; pSk = 1'b0;
    forever begin
      @(eeSk or eeCs);
      if (eeCs && !pCs) begin
        csRises++; rxCnt = 0; devDo = 1'b1; rxAddr = '0; rxOpc = '0;
      end
      if (!eeCs && pCs) begin
        if (rxOpc != 3'b110) opcErr = 1;
        if (int'(rxAddr) != expAddr) orderErr = 1;
        expAddr++;
        lastAddr = rxAddr;
        devDo = 1'b1;
      end
      if (eeSk && !pSk) begin
        pulses++;
        if (!eeCs) csErr = 1;
        if (rxCnt < 3) rxOpc = {rxOpc[1:0], eeDi};
        else if (rxCnt < 3 + devW) rxAddr = {rxAddr[14:0], eeDi};
        else if (eeDi) diErr = 1;
        if (rxCnt == 2 + devW) begin
          devDo = 1'b0; dIdx = 15;
        end else if (rxCnt > 2 + devW && dIdx >= 0) begin
          devDo = mem[rxAddr[AW-1:0]][dIdx]; dIdx--;
        end
        rxCnt++;
      end
      pCs = eeCs; pSk = eeSk;
    end
  end

  // ---------------- phase width monitor ----------------
  int hiRun = 0, loRun = 0;
  bit widthErr = 0;
  logic prevSk = 1'b0;
  always @(negedge clk) begin
    if (!eeCs) loRun = 0;
    if (eeSk && !prevSk) begin
      if (loRun != HALF) widthErr = 1;
      hiRun = 0;
    end
    if (!eeSk && prevSk) begin
      if (hiRun != HALF) widthErr = 1;
      loRun = 0;
    end
    if (eeSk) hiRun++;
    else if (eeCs) loRun++;
    prevSk = eeSk;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] expWord(input logic [AW-1:0] a, input int w);
    return mem[int'(a) >> (AW - w)];
  endfunction

  function automatic logic [15:0] imageSum();
    logic [15:0] s = '0;
    for (int i = 0; i < NW; i++) s = s + mem[i];
    return s;
  endfunction

  bit busyGap, pulseLong;

  task automatic clearMon();
    pulses = 0; csRises = 0; expAddr = 0;
    csErr = 0; diErr = 0; opcErr = 0; orderErr = 0; widthErr = 0;
    busyGap = 0; pulseLong = 0;
  endtask

  task automatic runTxn(input logic [AW-1:0] a, input bit boot, input bit restart,
                        output logic [15:0] d, output logic ok);
    int n;
    clearMon();
    @(negedge clk);
    wordAddr = a; bootMode = boot; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!dataValid && n < 40000) begin
      if (!busy) busyGap = 1;
      if (restart && n == 6) begin
        wordAddr = ~a; bootMode = 1'b0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    d = rdData; ok = sumOk;
    @(negedge clk);
    if (dataValid) pulseLong = 1;
  endtask

  task automatic checkWire(input string tag, input int expPulses, input logic [15:0] expA);
    chk(pulses == expPulses, tag, "eeSk pulse count", pulses, expPulses);
    chk(!csErr, "R2", "eeSk pulse without eeCs", csErr, 0);
    chk(!opcErr, "R3", "read command bits", rxOpc, 3'b110);
    chk(lastAddr == expA, "R4", "address received", lastAddr, expA);
    chk(!diErr, "R12", "eeDi high in data phase", diErr, 0);
    chk(!widthErr, "R8", "eeSk phase width", widthErr, 0);
    chk(!busyGap, "R11", "busy dropped early", busyGap, 0);
    chk(!pulseLong, "R11", "dataValid longer than one cycle", pulseLong, 0);
  endtask

  initial begin
    logic [15:0] d, s;
    logic ok;
    void'($urandom(32'd7331));
    for (int i = 0; i < NW; i++) mem[i] = 16'($urandom);

    repeat (3) @(negedge clk);
    // R1: reset values
    chk({eeCs, eeSk, eeDi, busy, dataValid, sumOk} == 6'b0, "R1", "outputs in reset",
        {eeCs, eeSk, eeDi, busy, dataValid, sumOk}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({eeCs, eeSk, eeDi, busy, dataValid, sumOk} == 6'b0, "R1", "outputs after reset",
        {eeCs, eeSk, eeDi, busy, dataValid, sumOk}, 0);

    // R7 / R4: directed corner addresses then random ones, full-width part
    for (int k = 0; k < 11; k++) begin
      logic [AW-1:0] a;
      a = (k == 0) ? '0 : (k == 1) ? '1 : (k == 2) ? AW'(6'h2A) : AW'($urandom);
      if (k == 2) mem[a] = 16'h8001;
      runTxn(a, 1'b0, 1'b0, d, ok);
      chk(d == expWord(a, AW), "R7", "single word data", d, expWord(a, AW));
      chk(ok == 1'b0, "R10", "sumOk after single read", ok, 0);
      checkWire("R5", 3 + AW + 16, 16'(a));
    end

    // R5: narrower part ends the address phase on its dummy zero
    devW = 4;
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      runTxn(a, 1'b0, 1'b0, d, ok);
      chk(d == expWord(a, 4), "R5", "narrow part data", d, expWord(a, 4));
      checkWire("R5", 3 + 4 + 16, 16'(int'(a) >> 2));
    end
    devW = AW;

    // R6: no dummy zero ever seen
    stuckHigh = 1'b1;
    runTxn(AW'(5), 1'b0, 1'b0, d, ok);
    chk(d == 16'hFFFF, "R6", "data with eeDo stuck high", d, 16'hFFFF);
    chk(pulses == 3 + AW + 16, "R6", "pulses with no dummy", pulses, 3 + AW + 16);
    stuckHigh = 1'b0;

    // R9 / R10: good image
    mem[NW-1] = 16'h0;
    s = imageSum();
    mem[NW-1] = 16'hBABA - s;
    runTxn('0, 1'b1, 1'b0, d, ok);
    chk(d == 16'hBABA, "R9", "boot sum", d, 16'hBABA);
    chk(ok == 1'b1, "R10", "sumOk on good image", ok, 1);
    chk(csRises == NW, "R9", "words read", csRises, NW);
    chk(!orderErr, "R9", "ascending address order", orderErr, 0);
    chk(pulses == NW * (3 + AW + 16), "R9", "boot pulse total", pulses, NW * (3 + AW + 16));
    chk(!csErr && !widthErr && !diErr, "R2", "boot wire timing", {csErr, widthErr, diErr}, 0);

    // R10: a single read afterwards clears sumOk
    runTxn(AW'(3), 1'b0, 1'b0, d, ok);
    chk(ok == 1'b0, "R10", "sumOk cleared by single read", ok, 0);
    chk(d == mem[3], "R7", "word after boot", d, mem[3]);

    // R10: corrupted image
    mem[17] = mem[17] + 16'h1;
    runTxn('0, 1'b1, 1'b0, d, ok);
    chk(d == imageSum(), "R9", "boot sum corrupted", d, imageSum());
    chk(d == 16'hBABB, "R9", "corrupted sum value", d, 16'hBABB);
    chk(ok == 1'b0, "R10", "sumOk on bad image", ok, 0);

    // R11: a start while busy is ignored
    runTxn(AW'(9), 1'b0, 1'b1, d, ok);
    chk(d == mem[9], "R11", "data with start while busy", d, mem[9]);
    chk(csRises == 1, "R11", "transactions with start while busy", csRises, 1);
    repeat (40) @(negedge clk);
    chk(!busy && !eeCs, "R11", "idle after ignored start", {busy, eeCs}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule